// File: doc/BRIEF.md
# UART Xon/Xoff software flow controller

This block carries out in-band flow control for one UART channel. Every character the receiver delivers passes through it on the way to the receive FIFO. It compares each character against four programmable flow characters. There are two resume characters, xon_a and xon_b, and two suspend characters, xoff_a and xoff_b. Matching can use one character or a pair of consecutive characters. A recognised flow character is removed from the data stream. It then sets or clears a suspend state, and that state keeps the transmit queue from feeding the transmitter.

The block also watches the fill level of the receive FIFO. With automatic sending enabled, it injects the suspend characters into the transmit stream once the level exceeds a trigger value. It injects the resume characters once the level has fallen back below that trigger. Injected characters go ahead of queued transmit data and are not blocked by the suspend state.

The transmitter loads a new character only when it signals `tx_ready`, which it does between characters. A suspend therefore never cuts a character in half. Received characters are expected at least two clock cycles apart, which any serial line rate comfortably meets.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset all four flow character registers read 0. A write with `reg_we` stores `reg_wdata` into the register picked by `reg_sel` (0 xon_a, 1 xon_b, 2 xoff_a, 3 xoff_b), and `reg_rdata` shows the register picked by `reg_sel`.
- R2: With `cfg_match_mode`=1 (single), a character equal to xoff_a sets `tx_suspend` and a character equal to xon_a clears it. xoff_a wins if both are equal. Neither flow character is written to the FIFO. Any other character, including xon_b and xoff_b, appears on `fifo_wr`/`fifo_data` one cycle after `rx_valid`.
- R3: With `cfg_match_mode`=2 (double), xoff_a followed by xoff_b sets `tx_suspend`, and xon_a followed by xon_b clears it. Both characters of a matched pair are dropped.
- R4: In double mode, if a first character that matched is followed by a character that does not complete its pair, the first character is written to the FIFO. The second character is then treated as a fresh first character. FIFO order always equals arrival order.
- R5: Only the low bits given by `cfg_word_len` take part in comparison (0: 5 bits, 1: 6 bits, 2: 7 bits, 3: 8 bits). Register bit 0 aligns with character bit 0.
- R6: With `cfg_xon_any`=1 and matching enabled, every character written to the FIFO as data also clears `tx_suspend`.
- R7: With `cfg_auto_send`=1, when no suspend has been sent and `rx_level` > `cfg_trig`, the block sends xoff_a then xoff_b in double mode, and only xoff_a otherwise. It sends them once per crossing, and a level equal to the trigger sends nothing.
- R8: After suspend characters were sent, `rx_level` < `cfg_trig` sends xon_a then xon_b (double) or xon_a alone, once.
- R9: Injected characters are loaded before queued data, even while `tx_suspend` is 1. Queued data is loaded and popped only while no injection is pending and `tx_suspend` is 0.
- R10: `tx_load` is asserted only in a cycle with `tx_ready` high.
- R11: With `cfg_match_mode`=0 every received character is written to the FIFO and `tx_suspend` never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Flow character register write strobe |
| reg_sel | input | 2 | Register select for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Selected register contents |
| cfg_match_mode | input | 2 | 0 off, 1 single, 2 double, 3 off |
| cfg_word_len | input | 2 | Character width code, 0..3 for 5..8 bits |
| cfg_xon_any | input | 1 | Any data character resumes |
| cfg_auto_send | input | 1 | Automatic flow character sending |
| cfg_trig | input | LVL_W | Receive level trigger |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_level | input | LVL_W | Receive FIFO fill level |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Receive FIFO write data |
| tx_ready | input | 1 | Transmitter at a character boundary, can load |
| txq_valid | input | 1 | Transmit queue has data |
| txq_data | input | 8 | Head of transmit queue |
| txq_pop | output | 1 | Transmit queue head consumed |
| tx_load | output | 1 | Character loaded into transmitter |
| tx_data | output | 8 | Character being loaded |
| tx_suspend | output | 1 | Remote side asked to stop transmission |

## Verification
A broken pair is the main target. The bench sends xon_a or xoff_a followed by an unrelated character, and also a pair start followed by another pair start. A design that discarded the half-match would lose data, and one that did not restart would miss the later pair. Masking is tested with characters whose high bits differ from the register, which a full-width comparator would let through as data. On the transmit side the level is held exactly at the trigger and then crosses it repeatedly. A design without crossing memory would resend the suspend characters on every cycle, and one with a wrong priority would interleave queued data inside a pair. Random mixes of flow and data characters in all modes are compared against a bench model of the stream.

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [1:0]       cfg_match_mode,
  input  logic [1:0]       cfg_word_len,
  input  logic             cfg_xon_any,
  input  logic             cfg_auto_send,
  input  logic [LVL_W-1:0] cfg_trig,
  input  logic             rx_valid,
  input  logic [7:0]       rx_char,
  input  logic [LVL_W-1:0] rx_level,
  output logic             fifo_wr,
  output logic [7:0]       fifo_data,
  input  logic             tx_ready,
  input  logic             txq_valid,
  input  logic [7:0]       txq_data,
  output logic             txq_pop,
  output logic             tx_load,
  output logic [7:0]       tx_data,
  output logic             tx_suspend
);
  localparam logic [1:0] M_SINGLE = 2'd1;
  localparam logic [1:0] M_DOUBLE = 2'd2;

  logic [7:0] xr [4];
  logic       susp_q, hold_v, hold_off, flush_v, wr_q;
  logic [7:0] hold_c, flush_c, wd_q;
  logic       xoff_sent, ins_busy, ins_off, ins_idx;

  function automatic logic hit(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m);
    return ((a ^ b) & m) == 8'd0;
  endfunction

  wire [7:0] mask    = 8'hFF >> (2'd3 - cfg_word_len);
  wire       h_xon1  = hit(rx_char, xr[0], mask);
  wire       h_xon2  = hit(rx_char, xr[1], mask);
  wire       h_xoff1 = hit(rx_char, xr[2], mask);
  wire       h_xoff2 = hit(rx_char, xr[3], mask);
  wire       h_first = h_xon1 | h_xoff1;
  wire       sec_hit = hold_off ? h_xoff2 : h_xon2;
  wire       dbl     = cfg_match_mode == M_DOUBLE;

  assign reg_rdata  = xr[reg_sel];
  assign fifo_wr    = wr_q;
  assign fifo_data  = wd_q;
  assign tx_suspend = susp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) xr[i] <= 8'd0;
    end else if (reg_we) begin
      xr[reg_sel] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      susp_q   <= 1'b0;
      hold_v   <= 1'b0;
      hold_off <= 1'b0;
      hold_c   <= 8'd0;
      flush_v  <= 1'b0;
      flush_c  <= 8'd0;
      wr_q     <= 1'b0;
      wd_q     <= 8'd0;
    end else begin
      wr_q <= 1'b0;
      if (flush_v) begin
        wr_q    <= 1'b1;
        wd_q    <= flush_c;
        flush_v <= 1'b0;
      end
      if (rx_valid) begin
        if (cfg_match_mode == M_SINGLE) begin
          if (h_xoff1) susp_q <= 1'b1;
          else if (h_xon1) susp_q <= 1'b0;
          else begin
            wr_q <= 1'b1;
            wd_q <= rx_char;
            if (cfg_xon_any) susp_q <= 1'b0;
          end
        end else if (dbl) begin
          if (hold_v && sec_hit) begin
            susp_q <= hold_off;
            hold_v <= 1'b0;
          end else begin
            if (hold_v) begin
              wr_q <= 1'b1;
              wd_q <= hold_c;
              if (cfg_xon_any) susp_q <= 1'b0;
            end
            if (h_first) begin
              hold_v   <= 1'b1;
              hold_c   <= rx_char;
              hold_off <= h_xoff1;
            end else begin
              hold_v <= 1'b0;
              if (cfg_xon_any) susp_q <= 1'b0;
              if (hold_v) begin
                flush_v <= 1'b1;
                flush_c <= rx_char;
              end else begin
                wr_q <= 1'b1;
                wd_q <= rx_char;
              end
            end
          end
        end else begin
          wr_q <= 1'b1;
          wd_q <= rx_char;
        end
      end
    end
  end

  wire       ins_last = !dbl || ins_idx;
  wire [7:0] ins_char = ins_off ? (ins_idx ? xr[3] : xr[2]) : (ins_idx ? xr[1] : xr[0]);
  wire       q_go     = txq_valid & ~susp_q & ~ins_busy;

  assign tx_load = tx_ready & (ins_busy | q_go);
  assign txq_pop = tx_ready & q_go;
  assign tx_data = ins_busy ? ins_char : txq_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xoff_sent <= 1'b0;
      ins_busy  <= 1'b0;
      ins_off   <= 1'b0;
      ins_idx   <= 1'b0;
    end else if (ins_busy) begin
      if (tx_ready) begin
        if (ins_last) begin
          ins_busy  <= 1'b0;
          ins_idx   <= 1'b0;
          xoff_sent <= ins_off;
        end else begin
          ins_idx <= 1'b1;
        end
      end
    end else if (cfg_auto_send) begin
      if (!xoff_sent && rx_level > cfg_trig) begin
        ins_busy <= 1'b1;
        ins_off  <= 1'b1;
        ins_idx  <= 1'b0;
      end else if (xoff_sent && rx_level < cfg_trig) begin
        ins_busy <= 1'b1;
        ins_off  <= 1'b0;
        ins_idx  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xonxoff_flow_ctrl_chk.sv
module xonxoff_flow_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_match_mode,
  input logic       rx_valid,
  input logic       fifo_wr,
  input logic       tx_ready,
  input logic       txq_valid,
  input logic [7:0] txq_data,
  input logic       txq_pop,
  input logic       tx_load,
  input logic [7:0] tx_data,
  input logic       tx_suspend
);
  a_r10_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> tx_ready);

  a_r9_no_pop_when_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> (!tx_suspend && txq_valid));

  a_r9_pop_loads_queue_head: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> (tx_load && tx_data == txq_data));

  a_r2_write_follows_rx: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> ($past(rx_valid) || $past(rx_valid, 2)));

  a_r11_off_mode_keeps_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_match_mode == 2'd0 || cfg_match_mode == 2'd3) |=> $stable(tx_suspend));
endmodule

bind xonxoff_flow_ctrl xonxoff_flow_ctrl_chk chk_i (.*);

// File: tb/xonxoff_flow_ctrl_tb_top.sv
module xonxoff_flow_ctrl_tb_top;
  localparam int LVL_W = 7;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0; logic [1:0] reg_sel = 0; logic [7:0] reg_wdata = 0, reg_rdata;
  logic [1:0] cfg_match_mode = 0, cfg_word_len = 2'd3;
  logic cfg_xon_any = 0, cfg_auto_send = 0;
  logic [LVL_W-1:0] cfg_trig = 10, rx_level = 0;
  logic rx_valid = 0; logic [7:0] rx_char = 0;
  logic fifo_wr; logic [7:0] fifo_data;
  logic tx_ready = 0, txq_valid = 0; logic [7:0] txq_data = 0;
  logic txq_pop, tx_load, tx_suspend; logic [7:0] tx_data;

  always #4 clk = ~clk;

  xonxoff_flow_ctrl #(.LVL_W(LVL_W)) dut_i (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] got_f [1024]; int got_n = 0;
  logic [7:0] exp_f [1024]; int exp_n = 0;
  logic [7:0] tl_d [256]; bit tl_pop [256]; int tl_n = 0;
  logic [7:0] xr [4];
  bit e_susp = 0, e_hold_v = 0, e_hold_off = 0, e_flush = 0;
  logic [7:0] e_hold_c = 0;

  always @(negedge clk) begin
    if (rst_n && fifo_wr && got_n < 1024) begin got_f[got_n] = fifo_data; got_n++; end
    if (rst_n && tx_load && tl_n < 256) begin tl_d[tl_n] = tx_data; tl_pop[tl_n] = txq_pop; tl_n++; end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic bit eqm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] m = 8'hFF >> (2'd3 - cfg_word_len);
    return ((a ^ b) & m) == 0;
  endfunction

  task automatic push_exp(input logic [7:0] c);
    exp_f[exp_n] = c; exp_n++;
  endtask

  task automatic model_rx(input logic [7:0] c);
    bit f1 = eqm(c, xr[0]) || eqm(c, xr[2]);
    if (cfg_match_mode == 2'd1) begin
      if (eqm(c, xr[2])) e_susp = 1;
      else if (eqm(c, xr[0])) e_susp = 0;
      else begin push_exp(c); if (cfg_xon_any) e_susp = 0; end
    end else if (cfg_match_mode == 2'd2) begin
      if (e_hold_v && (e_hold_off ? eqm(c, xr[3]) : eqm(c, xr[1]))) begin
        e_susp = e_hold_off; e_hold_v = 0;
      end else begin
        if (e_hold_v) begin push_exp(e_hold_c); if (cfg_xon_any) e_susp = 0; end
        if (f1) begin e_hold_v = 1; e_hold_c = c; e_hold_off = eqm(c, xr[2]); end
        else begin e_hold_v = 0; push_exp(c); if (cfg_xon_any) e_susp = 0; end
      end
    end else push_exp(c);
  endtask

  task automatic send(input logic [7:0] c, input string req);
    model_rx(c);
    rx_valid = 1; rx_char = c; tick();
    rx_valid = 0; tick(3);
    check(req, tx_suspend, e_susp);
  endtask

  task automatic cmp_fifo(input string req);
    check(req, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) check(req, got_f[i], exp_f[i]);
  endtask

  task automatic wreg(input int s, input logic [7:0] v);
    reg_we = 1; reg_sel = 2'(s); reg_wdata = v; xr[s] = v; tick();
    reg_we = 0;
  endtask

  task automatic pull(input int n);
    tx_ready = 1; tick(n); tx_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    for (int i = 0; i < 4; i++) xr[i] = 0;
    tick(3); rst_n = 1; tick();
    check("R1 reset suspend", tx_suspend, 0);
    check("R1 reset fifo_wr", fifo_wr, 0);
    for (int i = 0; i < 4; i++) begin reg_sel = 2'(i); #1; check("R1 reset reg", reg_rdata, 0); end
    tx_ready = 1; #1; check("R10 idle no load", tx_load, 0); tx_ready = 0;

    wreg(0, 8'h11); wreg(1, 8'h22); wreg(2, 8'h13); wreg(3, 8'h33);
    for (int i = 0; i < 4; i++) begin reg_sel = 2'(i); #1; check("R1 readback", reg_rdata, xr[i]); end

    // R11 matching off: flow characters pass as data
    cfg_match_mode = 0;
    send(8'h13, "R11 off suspend"); send(8'h41, "R11 off suspend");
    cmp_fifo("R11 off passthrough");

    // R2 single mode
    cfg_match_mode = 1;
    send(8'h41, "R2 data"); send(8'h13, "R2 xoff_a suspends");
    // R9 suspended queue is held
    txq_valid = 1; txq_data = 8'hAA; tx_ready = 1;
    @(negedge clk);
    check("R9 suspended no load", tx_load, 0); check("R9 suspended no pop", txq_pop, 0);
    tick(); tx_ready = 0; txq_valid = 0; tl_n = 0;
    send(8'h33, "R2 xoff_b is data in single"); send(8'h11, "R2 xon_a resumes");
    send(8'h22, "R2 xon_b is data in single");
    cmp_fifo("R2 single stream");

    // R5 word length masking
    cfg_word_len = 0;
    send(8'hF3, "R5 5-bit xoff match"); check("R5 masked suspend", tx_suspend, 1);
    send(8'hF1, "R5 5-bit xon match"); check("R5 masked resume", tx_suspend, 0);
    cfg_word_len = 3;
    send(8'hF3, "R5 8-bit no match");
    cmp_fifo("R5 masking stream");

    // R6 any character resumes
    cfg_xon_any = 1;
    send(8'h13, "R6 suspend"); send(8'h55, "R6 data resumes");
    check("R6 resumed", tx_suspend, 0);
    cfg_xon_any = 0;

    // R3 / R4 double mode
    cfg_match_mode = 2;
    send(8'h13, "R3 first half"); send(8'h33, "R3 pair suspends");
    check("R3 suspended", tx_suspend, 1);
    send(8'h11, "R3 first half"); send(8'h22, "R3 pair resumes");
    check("R3 resumed", tx_suspend, 0);
    send(8'h13, "R4 half"); send(8'h41, "R4 broken pair");
    send(8'h11, "R4 half"); send(8'h13, "R4 restart"); send(8'h33, "R4 restarted pair");
    check("R4 restart suspends", tx_suspend, 1);
    send(8'h11, "R4 resume"); send(8'h22, "R4 resume");
    cmp_fifo("R4 double stream order");

    // random mix checked against bench model
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 5);
      logic [7:0] c;
      if (k % 50 == 0) begin
        if (!e_hold_v) cfg_match_mode = 2'($urandom_range(0, 2));
        cfg_xon_any = 1'($urandom_range(0, 1));
        cfg_word_len = 2'($urandom_range(0, 3));
      end
      c = (r < 4) ? xr[r] : 8'($urandom_range(0, 255));
      send(c, "R2 R3 R4 R6 random suspend");
    end
    cfg_match_mode = 2; cfg_xon_any = 0; cfg_word_len = 3;
    send(8'h41, "R4 drain"); tick(2);
    cmp_fifo("R4 random stream");

    // R7 / R8 automatic sending
    if (tx_suspend) begin send(8'h11, "R3 resume"); send(8'h22, "R3 resume"); end
    tl_n = 0; cfg_auto_send = 1; cfg_trig = 10; rx_level = 10; tick(3);
    pull(4); check("R7 level equal sends nothing", tl_n, 0);
    rx_level = 11; tick(3); pull(6);
    check("R7 double xoff count", tl_n, 2);
    check("R7 xoff_a first", tl_d[0], 8'h13); check("R7 xoff_b second", tl_d[1], 8'h33);
    rx_level = 10; tick(3); pull(4);
    check("R8 equal level no xon", tl_n, 2);
    rx_level = 9; tick(3); pull(6);
    check("R8 xon count", tl_n, 4);
    check("R8 xon_a", tl_d[2], 8'h11); check("R8 xon_b", tl_d[3], 8'h22);

    // R9 insertion ahead of queued data
    tl_n = 0; txq_valid = 1; txq_data = 8'hAA; rx_level = 12; tick(3); pull(4);
    check("R9 load count", tl_n, 4);
    check("R9 xoff_a first", tl_d[0], 8'h13); check("R9 no pop on flow", tl_pop[0], 0);
    check("R9 xoff_b next", tl_d[1], 8'h33); check("R9 no pop on flow", tl_pop[1], 0);
    check("R9 queue after", tl_d[2], 8'hAA); check("R9 pop on queue", tl_pop[2], 1);

    // R7 / R8 single mode sends one character
    tl_n = 0; cfg_match_mode = 1; rx_level = 3; tick(3); pull(2);
    check("R8 single xon_a", tl_d[0], 8'h11); check("R8 single then queue", tl_d[1], 8'hAA);
    txq_valid = 0; tick(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule